// File: doc/BRIEF.md
# System Clock Divisor Selection Logic

The block holds two run-mode clock configuration words, a primary one and an extended one. A one-word register port with a single address bit writes and reads them. From whichever fields are active, the block works out three things: the path the system clock takes (PLL reference or bypass oscillator), the source code, and the effective division ratio. It then divides the tick stream of the selected path into a one-cycle system clock enable.

The primary word carries a 4-bit divider field. The extended word carries a 6-bit divider field and an override bit that makes its own source, bypass and divider fields win over the primary ones. In the extended word, a fine-step enable bit appends one more LSB to the divider field. This gives half-step ratios on the undivided PLL reference; otherwise the PLL reference is first halved. Reserved settings raise a flag.

Software must make some other register access between a primary write and an extended write. An extended write that comes directly after a primary write sets a sticky status output.

Top module: `sysclk_div_sel`

## Requirements
- R1: After reset the primary word reads 0x0000011F (divider code 0xF, use-divider set, bypass set). The extended word reads 0. div_o is 16, pll_path_o is 0, and cfg_invalid_o and seq_viol_o are 0.
- R2: A word reads back what was written, ANDed with its mask. The primary mask is 0x0000311F: divider [3:0], use-divider [4], bypass [8], source [13:12]. The extended mask is 0xDFC00870: source [6:4], bypass [11], fine LSB [22], divider [28:23], fine enable [30], override [31]. Address 0 selects the primary word and address 1 the extended word.
- R3: With override clear, bypass set and use-divider set, the ratio is primary divider code + 1, and ticks are counted on osc_tick_i.
- R4: With bypass in effect and use-divider clear, the ratio is 1: every oscillator tick gives an enable pulse.
- R5: With bypass clear, the PLL reference is halved first: the ratio is 2 × (code + 1) and ticks come from pll_tick_i only. Oscillator ticks then produce no pulse.
- R6: With override set, the extended source, bypass and 6-bit divider fields replace the primary ones, and src_o shows the extended source. With override clear, src_o is the primary source with a zero MSB. The use-divider bit always comes from the primary word.
- R7: With override set, fine enable set and extended bypass clear, the ratio is {divider, fine LSB} + 1, up to 128, counted on pll_tick_i with no halving. If fine enable is clear, or bypass is in effect, the fine LSB and fine enable are ignored.
- R8: cfg_invalid_o is 1 in two cases: on the halved PLL path with a divider code of 0 or 1, and on the fine-step path with a ratio of 4 or less. It is 0 for every other setting.
- R9: seq_viol_o is set by an extended write when the most recent register access was a primary write. Idle cycles are not accesses. Reads and extended writes are accesses. Once set, it stays set until reset.
- R10: sys_en_o is a one-cycle pulse issued on every N-th tick of the selected path, where N = div_o. When N or the path changes, the tick count restarts, so the next pulse comes on the N-th tick after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (counts as an access) |
| reg_addr_i | input | 1 | 0 selects the primary word, 1 the extended word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed word |
| pll_tick_i | input | 1 | Tick of the undivided PLL reference |
| osc_tick_i | input | 1 | Tick of the bypass oscillator |
| sys_en_o | output | 1 | System clock enable pulse |
| div_o | output | 8 | Resolved ratio in ticks of the selected path |
| pll_path_o | output | 1 | 1 when the PLL path is selected |
| src_o | output | 3 | Active source code |
| cfg_invalid_o | output | 1 | Reserved configuration flag |
| seq_viol_o | output | 1 | Sticky register sequencing violation |

## Verification
The bench builds the block with the package defaults: a 4-bit primary divider, a 6-bit extended divider and an 8-bit tick counter. With these, every path can be reached, including the extreme ratio of 128 on the fine-step path and the ratio of 1 in the no-divide bypass case. The table covers all four ways of resolving the ratio, as well as the reserved low codes on both PLL variants. The directed tests then probe the restart of the tick count after a ratio change, the blocking of the unselected tick stream, and the way idle cycles and reads interact with the sequencing check.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;
  localparam int REG_W     = 32;
  localparam int PRI_DIV_W = 4;
  localparam int EXT_DIV_W = PRI_DIV_W + 2;
  localparam int FINE_W    = EXT_DIV_W + 1;
  localparam int CNT_W     = FINE_W + 1;
  localparam int SRC_W     = 3;
  localparam int PRI_SRC_W = 2;

  // primary word layout
  localparam int PRI_DIV_LO = 0;
  localparam int PRI_USE_B  = 4;
  localparam int PRI_BYP_B  = 8;
  localparam int PRI_SRC_LO = 12;

  // extended word layout
  localparam int EXT_SRC_LO = 4;
  localparam int EXT_BYP_B  = 11;
  localparam int EXT_LSB_B  = 22;
  localparam int EXT_DIV_LO = 23;
  localparam int EXT_FINE_B = 30;
  localparam int EXT_OVR_B  = 31;

  localparam logic [REG_W-1:0] PRI_MASK =
      (REG_W'((1 << PRI_DIV_W) - 1) << PRI_DIV_LO) |
      (REG_W'(1) << PRI_USE_B) | (REG_W'(1) << PRI_BYP_B) |
      (REG_W'((1 << PRI_SRC_W) - 1) << PRI_SRC_LO);
  localparam logic [REG_W-1:0] EXT_MASK =
      (REG_W'((1 << SRC_W) - 1) << EXT_SRC_LO) |
      (REG_W'(1) << EXT_BYP_B) | (REG_W'(1) << EXT_LSB_B) |
      (REG_W'((1 << EXT_DIV_W) - 1) << EXT_DIV_LO) |
      (REG_W'(1) << EXT_FINE_B) | (REG_W'(1) << EXT_OVR_B);
  localparam logic [REG_W-1:0] PRI_RESET =
      (REG_W'((1 << PRI_DIV_W) - 1) << PRI_DIV_LO) |
      (REG_W'(1) << PRI_USE_B) | (REG_W'(1) << PRI_BYP_B);

  typedef struct packed {
    logic             pll_path;
    logic [CNT_W-1:0] ratio;
    logic             invalid;
    logic [SRC_W-1:0] src;
  } clk_cfg_t;
endpackage

// File: rtl/sysclk_cfg_regs.sv
module sysclk_cfg_regs
  import sysclk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] pri_o,
  output logic [REG_W-1:0] ext_o,
  output logic             seq_viol_o
);
  logic [REG_W-1:0] pri_q, ext_q;
  logic armed_q, viol_q;
  logic tight_ext_wr;

  assign tight_ext_wr = we_i && addr_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q   <= PRI_RESET;
      ext_q   <= '0;
      armed_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      if (we_i && !addr_i) pri_q <= wdata_i & PRI_MASK;
      if (we_i && addr_i)  ext_q <= wdata_i & EXT_MASK;
      // last access was a primary write
      if (we_i || re_i) armed_q <= we_i && !addr_i;
      if (tight_ext_wr) viol_q <= 1'b1;
    end
  end

  assign rdata_o    = addr_i ? ext_q : pri_q;
  assign pri_o      = pri_q;
  assign ext_o      = ext_q;
  assign seq_viol_o = viol_q;

  a_r9_tight_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && armed_q) |=> seq_viol_o);
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_viol_o |=> seq_viol_o);
  a_r2_pri_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !addr_i) |=> $stable(pri_o));
  a_r2_ext_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i) |=> $stable(ext_o));
endmodule

// File: rtl/sysclk_div_resolve.sv
module sysclk_div_resolve
  import sysclk_div_pkg::*;
(
  input  logic [REG_W-1:0] pri_i,
  input  logic [REG_W-1:0] ext_i,
  output clk_cfg_t         cfg_o
);
  logic ovr, bypass, use_div, fine;
  logic [CNT_W-1:0] d_pri, d_ext, d_fine, d_sel;

  assign ovr     = ext_i[EXT_OVR_B];
  assign bypass  = ovr ? ext_i[EXT_BYP_B] : pri_i[PRI_BYP_B];
  assign use_div = pri_i[PRI_USE_B];
  assign fine    = ovr && ext_i[EXT_FINE_B] && !bypass;

  assign d_pri  = CNT_W'(pri_i[PRI_DIV_LO +: PRI_DIV_W]) + CNT_W'(1);
  assign d_ext  = CNT_W'(ext_i[EXT_DIV_LO +: EXT_DIV_W]) + CNT_W'(1);
  assign d_fine = CNT_W'({ext_i[EXT_DIV_LO +: EXT_DIV_W], ext_i[EXT_LSB_B]}) + CNT_W'(1);
  assign d_sel  = ovr ? d_ext : d_pri;

  always_comb begin
    cfg_o.pll_path = !bypass;
    cfg_o.src      = ovr ? ext_i[EXT_SRC_LO +: SRC_W]
                         : {1'b0, pri_i[PRI_SRC_LO +: PRI_SRC_W]};
    if (bypass) begin
      cfg_o.ratio   = use_div ? d_sel : CNT_W'(1);
      cfg_o.invalid = 1'b0;
    end else if (fine) begin
      cfg_o.ratio   = d_fine;
      cfg_o.invalid = d_fine <= CNT_W'(4);
    end else begin
      cfg_o.ratio   = d_sel << 1;          // halved PLL reference
      cfg_o.invalid = d_sel <= CNT_W'(2);
    end
  end

  always_comb begin
    a_r10_ratio_nonzero: assert (cfg_o.ratio != '0);
    if (cfg_o.pll_path && !cfg_o.invalid)
      a_r8_valid_pll_floor: assert (cfg_o.ratio >= CNT_W'(5));
  end
endmodule

// File: rtl/sysclk_tick_div.sv
module sysclk_tick_div
  import sysclk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             path_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q, ratio_q;
  logic path_q, en_q, reload, last;

  assign reload = (ratio_i != ratio_q) || (path_i != path_q);
  assign last   = cnt_q == ratio_i - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= CNT_W'(1);
      path_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      ratio_q <= ratio_i;
      path_q  <= path_i;
      if (reload) begin
        cnt_q <= '0;
        en_q  <= 1'b0;
      end else if (tick_i) begin
        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        en_q  <= last;
      end else begin
        en_q  <= 1'b0;
      end
    end
  end

  assign en_o = en_q;

  a_r10_pulse_from_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> $past(tick_i));
  a_r10_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  a_r10_reload_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i != ratio_q) |=> (cnt_q == '0) && !en_o);
endmodule

// File: rtl/sysclk_div_sel.sv
module sysclk_div_sel
  import sysclk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             pll_tick_i,
  input  logic             osc_tick_i,
  output logic             sys_en_o,
  output logic [CNT_W-1:0] div_o,
  output logic             pll_path_o,
  output logic [SRC_W-1:0] src_o,
  output logic             cfg_invalid_o,
  output logic             seq_viol_o
);
  logic [REG_W-1:0] pri, ext;
  clk_cfg_t cfg;
  logic tick_sel;

  sysclk_cfg_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pri_o(pri), .ext_o(ext), .seq_viol_o(seq_viol_o)
  );

  sysclk_div_resolve u_resolve (.pri_i(pri), .ext_i(ext), .cfg_o(cfg));

  assign tick_sel = cfg.pll_path ? pll_tick_i : osc_tick_i;

  sysclk_tick_div u_div (
    .clk_i, .rst_ni, .tick_i(tick_sel), .path_i(cfg.pll_path),
    .ratio_i(cfg.ratio), .en_o(sys_en_o)
  );

  assign div_o         = cfg.ratio;
  assign pll_path_o    = cfg.pll_path;
  assign src_o         = cfg.src;
  assign cfg_invalid_o = cfg.invalid;

  a_r5_no_osc_pulse_on_pll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_path_o && $stable(pll_path_o) && !pll_tick_i) |=> !sys_en_o);
endmodule

// File: tb/sysclk_div_sel_test.sv
module sysclk_div_sel_test;
  logic clk = 0, rst_n = 0;
  logic we = 0, re = 0, addr = 0, pll_t = 0, osc_t = 0;
  logic [31:0] wdata = 0, rdata;
  logic sys_en, pll_path, invalid, viol;
  logic [7:0] div;
  logic [2:0] src;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysclk_div_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pll_tick_i(pll_t), .osc_tick_i(osc_t),
    .sys_en_o(sys_en), .div_o(div), .pll_path_o(pll_path), .src_o(src),
    .cfg_invalid_o(invalid), .seq_viol_o(viol)
  );

  typedef struct packed {
    logic [31:0] pri;
    logic [31:0] ext;
    logic [7:0]  n;
    logic        inv;
    logic        pll;
    logic [2:0]  src;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_2114, 32'h0000_0000, 8'd5,   1'b0, 1'b0, 3'd2},
    '{32'h0000_0107, 32'h0000_0000, 8'd1,   1'b0, 1'b0, 3'd0},
    '{32'h0000_0013, 32'h0000_0000, 8'd8,   1'b0, 1'b1, 3'd0},
    '{32'h0000_0011, 32'h0000_0000, 8'd4,   1'b1, 1'b1, 3'd0},
    '{32'h0000_0010, 32'h0000_0000, 8'd2,   1'b1, 1'b1, 3'd0},
    '{32'h0000_0110, 32'h9400_0850, 8'd41,  1'b0, 1'b0, 3'd5},
    '{32'h0000_0110, 32'h8480_0000, 8'd20,  1'b0, 1'b1, 3'd0},
    '{32'h0000_0110, 32'h84C0_0000, 8'd20,  1'b0, 1'b1, 3'd0},
    '{32'h0000_0110, 32'hC240_0000, 8'd10,  1'b0, 1'b1, 3'd0},
    '{32'h0000_0110, 32'hC100_0000, 8'd5,   1'b0, 1'b1, 3'd0},
    '{32'h0000_0110, 32'hC0C0_0000, 8'd4,   1'b1, 1'b1, 3'd0},
    '{32'h0000_0110, 32'hC240_0800, 8'd5,   1'b0, 1'b0, 3'd0},
    '{32'h0000_0110, 32'hDFC0_0000, 8'd128, 1'b0, 1'b1, 3'd0},
    '{32'h0000_0100, 32'h8000_0800, 8'd1,   1'b0, 1'b0, 3'd0}
  };
  localparam string TAGS [NV] = '{"R3", "R4", "R5", "R8", "R8", "R6", "R6",
                                  "R7", "R7", "R7", "R8", "R7", "R7", "R4"};

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a;
    #0 d = rdata;
    #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic set_tick(input logic pll, input logic on);
    pll_t = pll & on;
    osc_t = !pll & on;
  endtask

  task automatic period(input logic pll, output int per);
    int i;
    per = -1;
    @(negedge clk); set_tick(pll, 1);
    for (i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sys_en) break;
    end
    if (i < 400) begin
      per = 0;
      for (int j = 0; j < 400; j++) begin
        @(negedge clk);
        per++;
        if (sys_en) break;
      end
    end
    set_tick(pll, 0);
  endtask

  task automatic ticks_to_pulse(input logic pll, output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      set_tick(pll, 1);
      n++;
      @(negedge clk);
      set_tick(pll, 0);
      if (sys_en) break;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int per, n, pulses;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "div", div, 16);
    check("R1", "pll_path", pll_path, 0);
    check("R1", "invalid", invalid, 0);
    check("R1", "seq_viol", viol, 0);
    rd(0, d); check("R1", "primary read", d, 32'h0000_011F);
    rd(1, d); check("R1", "extended read", d, 0);

    for (int v = 0; v < NV; v++) begin
      wr(0, VECS[v].pri);
      rd(0, d);
      wr(1, VECS[v].ext);
      repeat (2) @(negedge clk);
      check(TAGS[v], "div", div, VECS[v].n);
      check(TAGS[v], "pll_path", pll_path, VECS[v].pll);
      check("R8", "invalid", invalid, VECS[v].inv);
      check("R6", "src", src, VECS[v].src);
      period(VECS[v].pll, per);
      check("R10", "pulse period", per, VECS[v].n);
    end
    check("R9", "no violation with spacer access", viol, 0);

    // R2 masked readback
    wr(0, 32'hFFFF_FFFF); rd(1, d);
    wr(1, 32'hFFFF_FFFF);
    rd(0, d); check("R2", "primary mask", d, 32'h0000_311F);
    rd(1, d); check("R2", "extended mask", d, 32'hDFC0_0870);

    // R5 oscillator ticks ignored on PLL path
    wr(0, 32'h0000_0013); rd(0, d); wr(1, 0);
    repeat (2) @(negedge clk);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      osc_t = 1; @(negedge clk);
      if (sys_en) pulses++;
    end
    osc_t = 0;
    check("R5", "pulses from osc on pll path", pulses, 0);

    // R10 reload on ratio change
    wr(0, 32'h0000_0116); rd(0, d); wr(1, 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      osc_t = 1; @(negedge clk);
    end
    osc_t = 0;
    wr(0, 32'h0000_0114);
    repeat (2) @(negedge clk);
    ticks_to_pulse(0, n);
    check("R10", "ticks to first pulse after change", n, 5);
    @(negedge clk);
    check("R10", "pulse one cycle wide", sys_en, 0);

    // R9 idle cycles are not accesses
    wr(0, 32'h0000_0114);
    repeat (3) @(negedge clk);
    check("R9", "no flag before extended write", viol, 0);
    wr(1, 0);
    check("R9", "flag after idle-gapped write", viol, 1);
    rd(0, d); wr(1, 0);
    check("R9", "flag sticky", viol, 1);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", "seq_viol cleared by reset", viol, 0);
    check("R1", "div after reset", div, 16);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule